// File: doc/BRIEF.md
# Serial Dual Wiper Register

This block models the digital side of a two-channel digital potentiometer that a host loads over a three-wire serial link. The link carries a frame-enable line, a serial clock and a serial data line. While the frame line is high, each rising edge of the serial clock pushes one data bit into a shift chain. When the frame line drops, the chain contents become the live wiper codes and the stack selection. Shifting alone never moves a wiper. The serial pins are sampled by the block clock, so the serial clock must stay high and low for at least one block-clock period each.

The last stage of the chain drives a cascade pin. Several devices can share the frame and serial clock lines, with each cascade pin feeding the data input of the next device. They then act as one long shift register. If the cascade pin is looped back to the data input, the host can read a word out and leave it in place. After a power-up reset both wipers sit at mid-scale until a restore pulse loads a stored word. A stacked output routes one of the two wiper codes, chosen by the stack bit. Code 0 is the low end of the ladder and the all-ones code is the high end.

Top module: `dual_wiper_serial`

## Requirements
- R1: A data bit is taken on the first block-clock cycle in which the serial clock is seen high after being low, and only while the frame line is high. A serial clock held high for several cycles takes exactly one bit.
- R2: A frame is 17 bits long: the stack bit first, then the 8-bit wiper 1 code MSB first, then the 8-bit wiper 0 code MSB first. After the frame closes, the outputs show exactly those values.
- R3: Wiper codes and the stack bit change only on the cycle after the frame line falls, or after a restore pulse. Bits shifted inside an open frame leave all outputs unchanged.
- R4: The cascade output is the last stage of the chain. After a full 17-bit frame it equals the stack bit just sent. For two chained devices loaded with 34 bits, the first 17 bits land in the far device and the last 17 bits in the near device.
- R5: Serial clock edges while the frame line is low are ignored, and the chain holds its contents. An empty frame opened and closed afterwards re-commits the held word unchanged.
- R6: After power-up reset both wipers read 0x80, the stack bit reads 0 and the cascade output reads 0.
- R7: A one-cycle restore pulse loads restore_word into the outputs, using the frame layout: bit 16 is the stack bit, bits 15:8 are wiper 1 and bits 7:0 are wiper 0. This ends the mid-scale state. If a frame commit falls on the same cycle, the commit wins.
- R8: The stacked output shows wiper 1 when the stack bit is 1 and wiper 0 when it is 0. This covers the extreme codes 0x00 and 0xFF.
- R9: No bits are counted. An 18th rising edge shifts the chain once more, so the committed word is the last 17 bits received and is misaligned.
- R10: Looping the cascade output back to the data input for 17 edges in one frame leaves the chain, and so the committed word, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst_n | input | 1 | Active-low power-up reset |
| frame_en | input | 1 | Frame enable, active high; its falling edge commits |
| sclk | input | 1 | Serial clock, rising edge shifts |
| sdata | input | 1 | Serial data |
| restore | input | 1 | One-cycle pulse that loads restore_word |
| restore_word | input | 17 | Stored word: stack, wiper 1, wiper 0 |
| wiper0 | output | 8 | Committed wiper 0 code |
| wiper1 | output | 8 | Committed wiper 1 code |
| stack_sel | output | 1 | Committed stack bit |
| stacked | output | 8 | Wiper 0 or wiper 1, chosen by stack_sel |
| cascade_out | output | 1 | Last chain stage, feeds the next device |

## Verification
The bench builds two instances with the default 8-bit code width and connects the first one's cascade output to the second one's data input. This makes a 34-bit chain, so the ordering across devices can be checked. With the default width, the 18-edge misalignment can be checked against a hand-computed word, and the 0x80 mid-scale value is checked against a fixed constant.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int unsigned WIPERS = 2;

  function automatic int unsigned frame_bits(input int unsigned code_w);
    return 1 + WIPERS * code_w;
  endfunction

  typedef enum logic {
    ROUTE_W0 = 1'b0,
    ROUTE_W1 = 1'b1
  } route_e;
endpackage

// File: rtl/dwr_frame_ctl.sv
module dwr_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en_i,
  input  logic sclk_i,
  output logic shift_o,
  output logic commit_o
);
  logic sclk_q;
  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      frame_q <= frame_en_i;
    end
  end

  assign shift_o  = frame_en_i & sclk_i & ~sclk_q;
  assign commit_o = frame_q & ~frame_en_i;

  p_single_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |=> !shift_o);

  p_commit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
endmodule

// File: rtl/dwr_shift_chain.sv
module dwr_shift_chain #(
  parameter int unsigned BITS = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_i,
  input  logic            din_i,
  output logic [BITS-1:0] word_o,
  output logic            last_o
);
  logic [BITS-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (shift_i) stage_q <= {stage_q[BITS-2:0], din_i};
  end

  assign word_o = stage_q;
  assign last_o = stage_q[BITS-1];

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> word_o[0] == $past(din_i));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(word_o));

  p_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> last_o == $past(word_o[BITS-2]));
endmodule

// File: rtl/dwr_wiper_bank.sv
module dwr_wiper_bank
  import dwr_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned BITS  = 1 + WIPERS * CODE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_i,
  input  logic [BITS-1:0]               frame_word_i,
  input  logic                          restore_i,
  input  logic [BITS-1:0]               restore_word_i,
  output logic [WIPERS-1:0][CODE_W-1:0] wiper_o,
  output route_e                        route_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [BITS-1:0] src_word;
  logic            load;

  assign load     = commit_i | restore_i;
  assign src_word = commit_i ? frame_word_i : restore_word_i;

  for (genvar g = 0; g < WIPERS; g++) begin : g_wiper
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wiper_o[g] <= MID;
      else if (load) wiper_o[g] <= src_word[g*CODE_W +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_o <= ROUTE_W0;
    else if (load) route_o <= route_e'(src_word[BITS-1]);
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i && !restore_i |=> $stable(wiper_o) && $stable(route_o));

  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> wiper_o[0] == $past(frame_word_i[CODE_W-1:0]));

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i && !commit_i |=> wiper_o[1] == $past(restore_word_i[2*CODE_W-1:CODE_W]));
endmodule

// File: rtl/dual_wiper_serial.sv
module dual_wiper_serial
  import dwr_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned BITS  = 1 + WIPERS * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_en,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              restore,
  input  logic [BITS-1:0]   restore_word,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1,
  output logic              stack_sel,
  output logic [CODE_W-1:0] stacked,
  output logic              cascade_out
);
  logic                          shift;
  logic                          commit;
  logic [BITS-1:0]               chain_word;
  logic [WIPERS-1:0][CODE_W-1:0] wipers;
  route_e                        route;

  dwr_frame_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_en_i (frame_en),
    .sclk_i     (sclk),
    .shift_o    (shift),
    .commit_o   (commit)
  );

  dwr_shift_chain #(.BITS(BITS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift),
    .din_i   (sdata),
    .word_o  (chain_word),
    .last_o  (cascade_out)
  );

  dwr_wiper_bank #(.CODE_W(CODE_W)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .commit_i       (commit),
    .frame_word_i   (chain_word),
    .restore_i      (restore),
    .restore_word_i (restore_word),
    .wiper_o        (wipers),
    .route_o        (route)
  );

  assign wiper0    = wipers[0];
  assign wiper1    = wipers[1];
  assign stack_sel = (route == ROUTE_W1);

  always_comb begin
    unique case (route)
      ROUTE_W1: stacked = wipers[1];
      default:  stacked = wipers[0];
    endcase
  end

  p_shift_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> frame_en && sclk);

  p_route_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !restore |=> $stable(stacked));
endmodule

// File: tb/dual_wiper_serial_bench.sv
module dual_wiper_serial_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_en = 1'b0;
  logic        sclk = 1'b0;
  logic        sdata_drv = 1'b0;
  logic        loop_en = 1'b0;
  logic        restore = 1'b0;
  logic [16:0] restore_word = '0;
  logic [7:0]  w0_a, w1_a, st_a, w0_b, w1_b, st_b;
  logic        sk_a, sk_b, cas_a, cas_b, sd_a;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sd_a = loop_en ? cas_a : sdata_drv;

  dual_wiper_serial u_dual_wiper_serial (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .sclk(sclk), .sdata(sd_a),
    .restore(restore), .restore_word(restore_word),
    .wiper0(w0_a), .wiper1(w1_a), .stack_sel(sk_a), .stacked(st_a), .cascade_out(cas_a));

  dual_wiper_serial u_far (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .sclk(sclk), .sdata(cas_a),
    .restore(1'b0), .restore_word(17'h0),
    .wiper0(w0_b), .wiper1(w1_b), .stack_sel(sk_b), .stacked(st_b), .cascade_out(cas_b));

  typedef struct {
    int          dev;
    logic [16:0] word;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  event ev_chk;

  always @(ev_chk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [16:0] act;
      logic [7:0]  act_st, exp_st;
      e = exp_q.pop_front();
      act    = (e.dev == 0) ? {sk_a, w1_a, w0_a} : {sk_b, w1_b, w0_b};
      act_st = (e.dev == 0) ? st_a : st_b;
      exp_st = e.word[16] ? e.word[15:8] : e.word[7:0];
      checks++;
      if (act !== e.word || act_st !== exp_st) begin
        fails++;
        $display("FAIL %s dev%0d: word=%h stacked=%h expected word=%h stacked=%h",
                 e.tag, e.dev, act, act_st, e.word, exp_st);
      end
    end
  end

  task automatic expect_word(input int dev, input logic [16:0] w, input string tag);
    exp_t e;
    e.dev = dev; e.word = w; e.tag = tag;
    exp_q.push_back(e);
    -> ev_chk;
    @(negedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse(input int hi_cycles);
    sclk = 1'b1;
    repeat (hi_cycles) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [63:0] v, input int n, input int hi_cycles);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_drv = v[i];
      pulse(hi_cycles);
    end
  endtask

  task automatic open_frame();
    frame_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_frame();
    frame_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_frame(input logic [16:0] w, input int hi_cycles);
    open_frame();
    send_bits({47'h0, w}, 17, hi_cycles);
    close_frame();
  endtask

  initial begin
    logic [16:0] wa, wb, wc, wd, wr;
    repeat (3) @(negedge clk);
    // R6: mid-scale after power-up reset
    expect_word(0, 17'h08080, "R6 reset near");
    expect_word(1, 17'h08080, "R6 reset far");
    chk_bit(cas_a, 1'b0, "R6 cascade reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: restore pulse leaves mid-scale
    wr = 17'h1_5A_C3;
    restore_word = wr; restore = 1'b1;
    @(negedge clk);
    restore = 1'b0;
    @(negedge clk);
    expect_word(0, wr, "R7 restore");

    // R2/R3: frame A, check outputs unchanged before close
    wa = {1'b0, 8'hB0, 8'h40};
    open_frame();
    send_bits({47'h0, wa}, 17, 2);
    expect_word(0, wr, "R3 shifting holds outputs");
    close_frame();
    expect_word(0, wa, "R2 frame A");
    chk_bit(cas_a, wa[16], "R4 cascade equals stack bit A");

    // R1/R8: long high serial clock, stack=1 with extremes
    wb = {1'b1, 8'hFF, 8'h00};
    load_frame(wb, 5);
    expect_word(0, wb, "R1 R8 frame B long high");
    chk_bit(cas_a, 1'b1, "R4 cascade equals stack bit B");

    wc = {1'b0, 8'h00, 8'hFF};
    load_frame(wc, 2);
    expect_word(0, wc, "R8 frame C");

    // R5: edges with frame low ignored
    for (int k = 0; k < 5; k++) begin
      sdata_drv = 1'b1;
      pulse(2);
    end
    chk_bit(cas_a, wc[16], "R5 cascade held while idle");
    expect_word(0, wc, "R5 outputs held while idle");
    open_frame();
    close_frame();
    expect_word(0, wc, "R5 empty frame recommits held word");

    // R7: commit wins over a same-cycle restore
    wd = {1'b1, 8'h3C, 8'h81};
    open_frame();
    send_bits({47'h0, wd}, 17, 2);
    restore_word = 17'h0_11_22;
    frame_en = 1'b0; restore = 1'b1;
    @(negedge clk);
    restore = 1'b0;
    repeat (2) @(negedge clk);
    expect_word(0, wd, "R7 commit beats restore");

    // R9: 18 edges misalign the word
    begin
      logic [17:0] s18;
      s18 = {1'b0, 8'hB0, 8'h40, 1'b1};
      open_frame();
      send_bits({46'h0, s18}, 18, 2);
      close_frame();
      expect_word(0, s18[16:0], "R9 eighteenth edge misaligns");
      checks++;
      if (s18[16:0] == {1'b0, 8'hB0, 8'h40}) begin
        fails++;
        $display("FAIL R9: misaligned word=%h expected not %h", s18[16:0], 17'h0B040);
      end
    end

    // R4: two chained devices, far word sent first
    wa = {1'b1, 8'h12, 8'h34};
    wb = {1'b0, 8'hC7, 8'h9E};
    open_frame();
    send_bits({30'h0, wa, wb}, 34, 2);
    close_frame();
    expect_word(1, wa, "R4 chain far device");
    expect_word(0, wb, "R4 chain near device");

    // R10: loopback readback keeps the word
    loop_en = 1'b1;
    open_frame();
    for (int k = 0; k < 17; k++) pulse(2);
    close_frame();
    loop_en = 1'b0;
    expect_word(0, wb, "R10 loopback readback");
    chk_bit(cas_a, wb[16], "R10 cascade after readback");

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule